// File: doc/BRIEF.md
# E1 Transmit Timeslot Overlay Inserter

This block sits in the bit-serial transmit path of an E1 framer (32 timeslots of 8 bits, 16-frame multiframe) ahead of line coding. Each clock it takes one payload bit together with the current frame, timeslot and bit-position counters. It emits one output bit, which is either the payload bit or a substituted bit. Bits travel MSB first, so bit index 0 is bit 1 of the timeslot.

Two kinds of substitution exist. In channel-associated signalling mode, timeslot 16 of frame 0 is rebuilt as a four-zero alignment word, three spare bits and a remote multiframe alarm bit. In common-channel mode, timeslot 16 belongs to the payload and passes through untouched. Independently of the mode, a 32-bit per-timeslot mask can force whole timeslots to the idle pattern 11010101, but never timeslot 0 or timeslot 16. Configuration inputs are sampled at each timeslot boundary, so no timeslot is ever built from a mix of settings.

Top module: `e1_ts_overlay`

## Requirements
- R1: `ser_out` is registered and follows the inputs of the previous clock (one-clock latency). It reads 0 while `rst_n` is low. Bits that no other rule touches equal the delayed `ser_in`.
- R2: With `ccs_mode`=0, in frame 0 timeslot 16, bit indices 0–3 are sent as 0.
- R3: In that same slot, bit index 5 carries the alarm control `xreg[3]` (0 clears the bit, 1 sets it).
- R4: With `xbit_reg_sel`=1, the spare bits in that slot come from the register: index 4 from `xreg[0]`, index 6 from `xreg[1]` and index 7 from `xreg[2]`.
- R5: With `xbit_reg_sel`=0, the spare bits at indices 4, 6 and 7 equal `ext_xbit` as sampled on the same clock edge that takes in that bit position.
- R6: With `ccs_mode`=1, every bit of timeslot 16 passes unchanged in every frame. Timeslot 16 of frames 1–15 also passes unchanged in either mode.
- R7: When `idle_mask[k]`=1, all eight bits of timeslot k are replaced by 11010101, sent MSB first.
- R8: Timeslots 0 and 16 are never idled, whatever their mask bits hold.
- R9: `xreg[7:4]` are reserved and have no effect on `ser_out`.
- R10: `ccs_mode`, `xbit_reg_sel`, `xreg` and `idle_mask` are taken at bit index 0 of each timeslot and held for the rest of that timeslot. A change made in the middle of a timeslot first affects the next timeslot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_idx | input | 4 | Frame number within the multiframe, 0–15 |
| slot_idx | input | 5 | Timeslot number, 0–31 |
| bit_idx | input | 3 | Bit position within the timeslot, 0 = first (MSB) |
| ser_in | input | 1 | Payload bit for this position |
| ext_xbit | input | 1 | External spare-bit source |
| ccs_mode | input | 1 | 1 = common-channel (timeslot 16 is payload), 0 = associated signalling |
| xbit_reg_sel | input | 1 | 1 = spare bits from `xreg`, 0 = from `ext_xbit` |
| xreg | input | 8 | [0],[1],[2] spare bits, [3] remote multiframe alarm, [7:4] reserved |
| idle_mask | input | 32 | Bit k forces timeslot k to idle code |
| ser_out | output | 1 | Transmit bit, one clock late |

## Verification
The assertions assume that the counters advance like a real framer's. The bit index steps 0 to 7 and the timeslot changes only at index 0, so "index 0" marks a true timeslot boundary. The bench keeps to this by driving every timeslot as eight bits in order, starting at index 0. It jumps frame or slot numbers only at a boundary. All configuration changes come at index 0, except in the single deliberate mid-timeslot change that exercises the hold rule.

// File: rtl/e1ovl_pkg.sv
// Package: shared constants for the E1 transmit overlay.
// Assumes MSB-first bit order within a timeslot (index 0 = bit 1).
package e1ovl_pkg;
    localparam logic [7:0] IDLE_CODE   = 8'b1101_0101;
    localparam int         CAS_SLOT    = 16;
    localparam int         ALIGN_SLOT  = 0;
    localparam int         CAS_FRAME   = 0;
    // bit positions inside the rebuilt signalling slot
    localparam int         ALIGN_LAST  = 3;
    localparam int         POS_SPARE_A = 4;
    localparam int         POS_ALARM   = 5;
    localparam int         POS_SPARE_B = 6;
    localparam int         POS_SPARE_C = 7;
    // field positions inside the control byte
    localparam int         CTL_SPARE_A = 0;
    localparam int         CTL_SPARE_B = 1;
    localparam int         CTL_SPARE_C = 2;
    localparam int         CTL_ALARM   = 3;
    localparam int         CTL_USED    = 4;
endpackage

// File: rtl/e1ovl_cfg_hold.sv
// Module: e1ovl_cfg_hold
// Holds a configuration word for the length of one timeslot. At the
// boundary (bit index 0) the live word is used directly and captured.
// For the remaining bit positions the captured copy is used.
// Assumes: boundary is high exactly once per timeslot, on its first bit.
module e1ovl_cfg_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         boundary,
    input  logic [W-1:0] live,
    output logic [W-1:0] eff
);
    logic [W-1:0] shadow_q;

    // capture the live word on each timeslot boundary
    always_ff @(posedge clk) begin
        if (!rst_n)
            shadow_q <= '0;
        else if (boundary)
            shadow_q <= live;
    end

    // boundary uses the fresh value, the rest of the slot uses the capture
    always_comb begin
        eff = boundary ? live : shadow_q;
    end

    // R10: the effective word never changes inside a timeslot
    a_r10_cfg_steady: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !boundary) |-> (eff == $past(eff)));
endmodule

// File: rtl/e1ovl_sig_slot.sv
// Module: e1ovl_sig_slot
// Gives the bit to send at one position of the rebuilt signalling slot:
// the four-zero alignment word, three spare bits and the alarm bit.
// Assumes: bit_idx is the MSB-first position within the timeslot.
module e1ovl_sig_slot
    import e1ovl_pkg::*;
#(
    parameter int BW = 3
) (
    input  logic [BW-1:0]       bit_idx,
    input  logic [CTL_USED-1:0] ctl,
    input  logic                from_reg,
    input  logic                ext_bit,
    output logic                sig_bit
);
    logic spare_a, spare_b, spare_c;

    // choose register or external source for each spare bit
    always_comb begin
        spare_a = from_reg ? ctl[CTL_SPARE_A] : ext_bit;
        spare_b = from_reg ? ctl[CTL_SPARE_B] : ext_bit;
        spare_c = from_reg ? ctl[CTL_SPARE_C] : ext_bit;
    end

    // map the position to the alignment, spare or alarm bit
    always_comb begin
        if (int'(bit_idx) <= ALIGN_LAST)
            sig_bit = 1'b0;
        else if (int'(bit_idx) == POS_SPARE_A)
            sig_bit = spare_a;
        else if (int'(bit_idx) == POS_ALARM)
            sig_bit = ctl[CTL_ALARM];
        else if (int'(bit_idx) == POS_SPARE_B)
            sig_bit = spare_b;
        else if (int'(bit_idx) == POS_SPARE_C)
            sig_bit = spare_c;
        else
            sig_bit = 1'b0;
    end
endmodule

// File: rtl/e1ovl_idle_sel.sv
// Module: e1ovl_idle_sel
// Decides whether the current timeslot is forced to idle code and which
// idle bit goes with the current position. Timeslots 0 and 16 are exempt.
// Assumes: slot_idx < NUM_SLOTS.
module e1ovl_idle_sel
    import e1ovl_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int SW        = 5,
    parameter int BW        = 3
) (
    input  logic [SW-1:0]        slot_idx,
    input  logic [BW-1:0]        bit_idx,
    input  logic [NUM_SLOTS-1:0] mask,
    output logic                 force_idle,
    output logic                 idle_bit
);
    localparam int CODE_MSB = 7;
    logic [NUM_SLOTS-1:0] eligible;

    // per-slot eligibility: mask bit set and slot not protected
    genvar k;
    generate
        for (k = 0; k < NUM_SLOTS; k++) begin : g_slot
            if (k == ALIGN_SLOT || k == CAS_SLOT) begin : g_prot
                assign eligible[k] = 1'b0;
            end else begin : g_open
                assign eligible[k] = mask[k];
            end
        end
    endgenerate

    // pick this slot's flag and the MSB-first idle bit
    always_comb begin
        force_idle = eligible[slot_idx];
        idle_bit   = IDLE_CODE[CODE_MSB - int'(bit_idx)];
    end
endmodule

// File: rtl/e1_ts_overlay.sv
// Module: e1_ts_overlay (top)
// Bit-serial E1 transmit overlay. It rebuilds timeslot 16 of frame 0 in
// associated-signalling mode, forces masked timeslots to idle code, and
// passes all other bits through. The output is registered (latency 1).
// Priority: signalling slot, then idle, then payload.
// Assumes: the counters step like a framer's (bit index 0..7 in order).
module e1_ts_overlay
    import e1ovl_pkg::*;
#(
    parameter int NUM_SLOTS  = 32,
    parameter int SLOT_BITS  = 8,
    parameter int NUM_FRAMES = 16,
    parameter int CTL_W      = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [$clog2(NUM_FRAMES)-1:0] frame_idx,
    input  logic [$clog2(NUM_SLOTS)-1:0]  slot_idx,
    input  logic [$clog2(SLOT_BITS)-1:0]  bit_idx,
    input  logic                          ser_in,
    input  logic                          ext_xbit,
    input  logic                          ccs_mode,
    input  logic                          xbit_reg_sel,
    input  logic [CTL_W-1:0]              xreg,
    input  logic [NUM_SLOTS-1:0]          idle_mask,
    output logic                          ser_out
);
    localparam int SW     = $clog2(NUM_SLOTS);
    localparam int BW     = $clog2(SLOT_BITS);
    localparam int CFG_W  = 2 + CTL_USED + NUM_SLOTS;

    logic                  boundary;
    logic [CFG_W-1:0]      cfg_live, cfg_eff;
    logic                  ccs_eff, sel_eff;
    logic [CTL_USED-1:0]   ctl_eff;
    logic [NUM_SLOTS-1:0]  mask_eff;
    logic                  in_sig_slot, sig_bit, force_idle, idle_bit;
    logic                  nxt_bit;
    logic                  xreg_rsvd_unused;

    // reserved control bits are deliberately ignored
    assign xreg_rsvd_unused = ^xreg[CTL_W-1:CTL_USED];

    // pack live settings so one holder covers them all
    always_comb begin
        boundary = (bit_idx == '0);
        cfg_live = {ccs_mode, xbit_reg_sel, xreg[CTL_USED-1:0], idle_mask};
        {ccs_eff, sel_eff, ctl_eff, mask_eff} = cfg_eff;
    end

    e1ovl_cfg_hold #(.W(CFG_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .boundary (boundary),
        .live     (cfg_live),
        .eff      (cfg_eff)
    );

    e1ovl_sig_slot #(.BW(BW)) u_sig (
        .bit_idx  (bit_idx),
        .ctl      (ctl_eff),
        .from_reg (sel_eff),
        .ext_bit  (ext_xbit),
        .sig_bit  (sig_bit)
    );

    e1ovl_idle_sel #(.NUM_SLOTS(NUM_SLOTS), .SW(SW), .BW(BW)) u_idle (
        .slot_idx   (slot_idx),
        .bit_idx    (bit_idx),
        .mask       (mask_eff),
        .force_idle (force_idle),
        .idle_bit   (idle_bit)
    );

    // priority select between signalling, idle and payload
    always_comb begin
        in_sig_slot = !ccs_eff && (int'(frame_idx) == CAS_FRAME)
                      && (int'(slot_idx) == CAS_SLOT);
        if (in_sig_slot)
            nxt_bit = sig_bit;
        else if (force_idle)
            nxt_bit = idle_bit;
        else
            nxt_bit = ser_in;
    end

    // output register, cleared in reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            ser_out <= 1'b0;
        else
            ser_out <= nxt_bit;
    end

    // R2: alignment positions are zero
    a_r2_align_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!ccs_mode && boundary && frame_idx == '0 && int'(slot_idx) == CAS_SLOT)
        |=> (ser_out == 1'b0));
    // R3: alarm position follows the held alarm control
    a_r3_alarm_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sig_slot && int'(bit_idx) == POS_ALARM)
        |=> (ser_out == $past(ctl_eff[CTL_ALARM])));
    // R5: external spare bit sampled on the emitting edge
    a_r5_ext_spare: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sig_slot && !sel_eff && int'(bit_idx) == POS_SPARE_A)
        |=> (ser_out == $past(ext_xbit)));
    // R6: common-channel mode leaves timeslot 16 alone
    a_r6_ccs_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (ccs_eff && int'(slot_idx) == CAS_SLOT) |=> (ser_out == $past(ser_in)));
    // R8: timeslot 0 is always payload
    a_r8_ts0_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(slot_idx) == ALIGN_SLOT) |=> (ser_out == $past(ser_in)));
endmodule

// File: tb/e1_ts_overlay_bench.sv
module e1_ts_overlay_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  frame_idx = '0;
    logic [4:0]  slot_idx = '0;
    logic [2:0]  bit_idx = '0;
    logic        ser_in = 1'b0, ext_xbit = 1'b0;
    logic        ccs_mode = 1'b0, xbit_reg_sel = 1'b1;
    logic [7:0]  xreg = '0;
    logic [31:0] idle_mask = '0;
    logic        ser_out;

    int checks = 0, errors = 0;
    logic [15:0] lfsr = 16'hACE1;
    // model state: settings held from the slot boundary
    logic        m_ccs, m_sel;
    logic [7:0]  m_x;
    logic [31:0] m_mask;
    logic        pend = 1'b0, exp_q = 1'b0;
    string       tag_q = "", scen = "";

    always #4 clk = ~clk;   // 125 MHz

    e1_ts_overlay u_e1_ts_overlay (
        .clk(clk), .rst_n(rst_n), .frame_idx(frame_idx), .slot_idx(slot_idx),
        .bit_idx(bit_idx), .ser_in(ser_in), .ext_xbit(ext_xbit),
        .ccs_mode(ccs_mode), .xbit_reg_sel(xbit_reg_sel), .xreg(xreg),
        .idle_mask(idle_mask), .ser_out(ser_out)
    );

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: expected finish, got timeout");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic check(input logic exp, input string tag);
        checks++;
        if (ser_out !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", tag, scen, ser_out, exp);
        end
    endtask

    function automatic logic nextbit();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    // drive one bit position and check the one before it
    task automatic drive(input int f, input int s, input int b);
        logic idle_code [8];
        idle_code = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
        @(negedge clk);
        if (pend) check(exp_q, tag_q);
        frame_idx = 4'(f); slot_idx = 5'(s); bit_idx = 3'(b);
        ser_in = nextbit(); ext_xbit = nextbit();
        if (b == 0) begin
            m_ccs = ccs_mode; m_sel = xbit_reg_sel; m_x = xreg; m_mask = idle_mask;
        end
        if (!m_ccs && f == 0 && s == 16) begin
            case (b)
                0, 1, 2, 3: begin exp_q = 1'b0; tag_q = "R2"; end
                5:          begin exp_q = m_x[3]; tag_q = "R3"; end
                default: begin
                    if (m_sel) begin
                        exp_q = (b == 4) ? m_x[0] : (b == 6) ? m_x[1] : m_x[2];
                        tag_q = "R4";
                    end else begin
                        exp_q = ext_xbit; tag_q = "R5";
                    end
                end
            endcase
        end else if (s == 16) begin
            exp_q = ser_in; tag_q = "R6";
        end else if (s == 0) begin
            exp_q = ser_in; tag_q = "R8";
        end else if (m_mask[s]) begin
            exp_q = idle_code[b]; tag_q = "R7";
        end else begin
            exp_q = ser_in; tag_q = "R1";
        end
        pend = 1'b1;
    endtask

    task automatic run_frame(input int f);
        for (int s = 0; s < 32; s++)
            for (int b = 0; b < 8; b++)
                drive(f, s, b);
    endtask

    initial begin
        // R1: reset value
        ser_in = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        scen = "reset";
        check(1'b0, "R1");
        rst_n = 1'b1;

        // all slots masked, register spare bits: R7 R8 R2 R3 R4
        scen = "mask-all";
        ccs_mode = 0; xbit_reg_sel = 1; xreg = 8'h0A; idle_mask = '1;
        run_frame(0); run_frame(1);

        // external spare bits, alternating mask: R5
        scen = "ext-spare R5";
        xbit_reg_sel = 0; xreg = 8'h05; idle_mask = 32'h5555_AAAA;
        run_frame(0); run_frame(15);

        // common-channel mode: R6
        scen = "ccs R6";
        ccs_mode = 1; xbit_reg_sel = 1; xreg = 8'h0F; idle_mask = '1;
        run_frame(0);

        // every control value with reserved bits set opposite: R9 R3 R4
        ccs_mode = 0;
        for (int v = 0; v < 16; v++) begin
            scen = "reserved R9";
            xreg = {~4'(v), 4'(v)};
            for (int b = 0; b < 8; b++) drive(0, 16, b);
        end
        scen = "reserved R9 full";
        xreg = 8'hF6; idle_mask = 32'h0F0F_0F0F;
        run_frame(0);

        // mid-slot change only lands at next boundary: R10
        scen = "midslot R10";
        idle_mask = 32'h0000_0020; xreg = 8'h00;
        for (int s = 0; s < 32; s++)
            for (int b = 0; b < 8; b++) begin
                if (s == 5 && b == 3) idle_mask = 32'h0000_0040;
                if (s == 16 && b == 2) xreg = 8'h08;
                drive(0, s, b);
            end

        @(negedge clk);
        if (pend) check(exp_q, tag_q);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule